// File: doc/BRIEF.md
# Pulse-Per-Second Generator

This block turns the subseconds field of a free-running time-of-day counter into a timing pulse. Nodes on a synchronized network use it to compare their clocks on an oscilloscope. The subseconds value arrives on an input and the block decodes it into one output. A mode bit gives the subseconds format. In binary format the field counts in units of 2^-SUBW second and wraps at 2^SUBW. In decimal format it counts nanoseconds and wraps after 999,999,999.

A 4-bit rate code asks for 2^code pulses per second. The block does not use the code at once. It loads the code into an internal active-rate register at each seconds rollover, so a rate change always starts on a whole second and never leaves a stray short pulse. A code above the finest rate the field can show is clamped to that rate.

Every decision is registered, so the output changes one clock after the subseconds value that causes it.

Top module: `pps_pulse_gen`

## Requirements
- R1: While rst_n is low, pps_out is 0 and the active rate is 0 (1 Hz). After reset the 1 Hz rate holds until the first rollover, whatever freq_code is.
- R2: A rollover is a cycle in which sub_sec is lower than it was in the previous cycle. The active rate loads the clamped freq_code only in a rollover cycle, and that cycle already uses the new rate. In every other cycle the active rate keeps its value.
- R3: Binary mode (digital_mode=0) at rate 0: the output is high exactly when the three most significant bits of sub_sec are all zero, which is the first eighth of each second.
- R4: Binary mode at rate n ≥ 1: the output is high exactly when sub_sec bit (SUBW-1-n) is 0. This gives 2^n periods per second at 50% duty.
- R5: Decimal mode (digital_mode=1) at rate 0: the output is high exactly when sub_sec < 100,000,000, which is 100 ms per second.
- R6: Decimal mode at rate n ≥ 1: the output is high exactly when floor(sub_sec·2^(n+1) / 10^9) is even. Each second then holds exactly 2^n high pulses, although single periods may differ by 1 ns.
- R7: A freq_code above MAXN = min(15, SUBW-1) is loaded as MAXN.
- R8: pps_out is a register. It reflects the inputs sampled at the previous rising clock edge.
- R9: digital_mode acts on the next decision without waiting for a rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_sec | input | SUBW | Current subseconds value of the time counter |
| digital_mode | input | 1 | 0: binary subseconds, 1: nanosecond subseconds |
| freq_code | input | 4 | Requested rate, 2^code pulses per second |
| pps_out | output | 1 | Pulse output |

## Verification
The assertions rely on sub_sec staying within the range of the selected format. In decimal mode the value must stay below 10^9. A move to a lower value must come only from a real rollover, because the block treats every decrease as a new second. The bench keeps to this by advancing sub_sec by a fixed stride modulo the format's wrap value. It restarts at zero whenever it changes format, and it holds sub_sec constant when it toggles the mode bit. A second instance with a 10-bit field covers every subseconds value in binary mode, including the clamped codes.

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
  parameter int SUBW = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUBW-1:0] sub_sec,
  input  logic            digital_mode,
  input  logic [3:0]      freq_code,
  output logic            pps_out
);
  localparam int MAXN = (SUBW - 1 < 15) ? SUBW - 1 : 15;
  localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;
  localparam logic [63:0] NS_PULSE   = 64'd100_000_000;

  logic [SUBW-1:0] prev_q;
  logic [3:0]      rate_q;
  logic            wrap;
  logic [3:0]      code_c;
  logic [3:0]      rate_n;
  logic [SUBW-1:0] shifted;
  logic [63:0]     scaled;
  logic            bin_hi;
  logic            dig_hi;

  assign wrap    = sub_sec < prev_q;
  assign code_c  = (freq_code > 4'(MAXN)) ? 4'(MAXN) : freq_code;
  assign rate_n  = wrap ? code_c : rate_q;

  assign shifted = sub_sec << rate_n;
  assign bin_hi  = (rate_n == 4'd0) ? (shifted[SUBW-1 -: 3] == 3'b000) : ~shifted[SUBW-1];

  assign scaled  = 64'(sub_sec) << ({1'b0, rate_n} + 5'd1);
  assign dig_hi  = (rate_n == 4'd0) ? (64'(sub_sec) < NS_PULSE)
                                    : ~1'((scaled / NS_PER_SEC) & 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      rate_q  <= 4'd0;
      pps_out <= 1'b0;
    end else begin
      prev_q  <= sub_sec;
      rate_q  <= rate_n;
      pps_out <= digital_mode ? dig_hi : bin_hi;
    end
  end
endmodule

// File: rtl/pps_pulse_gen_chk.sv
module pps_pulse_gen_chk #(
  parameter int SUBW = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SUBW-1:0] sub_sec,
  input logic            digital_mode,
  input logic            pps_out,
  input logic [3:0]      rate_q,
  input logic            wrap
);
  localparam int MAXN = (SUBW - 1 < 15) ? SUBW - 1 : 15;

  logic [SUBW-1:0] sel_sh;
  assign sel_sh = sub_sec << rate_q;

  always @(negedge clk)
    if (!rst_n) a_r1_reset_low: assert (pps_out == 1'b0 && rate_q == 4'd0);

  a_r2_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> rate_q == $past(rate_q));

  a_r3_bin_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (!digital_mode && !wrap && rate_q == 4'd0) |=> pps_out == ($past(sub_sec[SUBW-1:SUBW-3]) == 3'b000));

  a_r4_bin_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (!digital_mode && !wrap && rate_q != 4'd0) |=> pps_out != $past(sel_sh[SUBW-1]));

  a_r5_dig_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (digital_mode && !wrap && rate_q == 4'd0) |=> pps_out == ($past(64'(sub_sec)) < 64'd100_000_000));

  a_r7_rate_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rate_q) <= MAXN);
endmodule

bind pps_pulse_gen pps_pulse_gen_chk #(.SUBW(SUBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_sec(sub_sec), .digital_mode(digital_mode),
  .pps_out(pps_out), .rate_q(rate_q), .wrap(wrap)
);

// File: tb/pps_pulse_gen_tb.sv
module pps_pulse_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190_000;
  localparam longint BIN_WRAP = 64'd1 << 31;
  localparam longint NS_WRAP  = 1_000_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [30:0] m_sub = '0;
  logic        m_dig = 1'b0;
  logic [3:0]  m_code = 4'd0;
  logic        m_out;
  logic [9:0]  s_sub = '0;
  logic [3:0]  s_code = 4'd0;
  logic        s_out;

  pps_pulse_gen #(.SUBW(31)) u_dut (
    .clk(clk), .rst_n(rst_n), .sub_sec(m_sub), .digital_mode(m_dig),
    .freq_code(m_code), .pps_out(m_out));

  pps_pulse_gen #(.SUBW(10)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .sub_sec(s_sub), .digital_mode(1'b0),
    .freq_code(s_code), .pps_out(s_out));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint mp_prev = 0; int mp_rate = 0; bit mp_exp; bit mp_valid = 0; string mp_tag;
  longint sp_prev = 0; int sp_rate = 0; bit sp_exp; bit sp_valid = 0; string sp_tag;

  function automatic bit model(longint s, int n, bit dig, int w);
    if (!dig) begin
      if (n == 0) return (s >> (w - 3)) == 0;
      return ((s >> (w - 1 - n)) & 1) == 0;
    end
    if (n == 0) return s < 100_000_000;
    return (((s << (n + 1)) / NS_WRAP) % 2) == 0;
  endfunction

  function automatic int clampc(int c, int w);
    int mx = (w - 1 < 15) ? w - 1 : 15;
    return (c > mx) ? mx : c;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pps_out=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step_m(input longint s, input bit d, input int c, input string tag);
    bit w;
    int ne;
    @(negedge clk);
    if (mp_valid) check(m_out, mp_exp, mp_tag);
    w = s < mp_prev;
    ne = w ? clampc(c, 31) : mp_rate;
    mp_rate = ne; mp_prev = s;
    mp_exp = model(s, ne, d, 31); mp_valid = 1; mp_tag = tag;
    m_sub = 31'(s); m_dig = d; m_code = 4'(c);
  endtask

  task automatic step_s(input longint s, input int c, input string tag);
    bit w;
    int ne;
    @(negedge clk);
    if (sp_valid) check(s_out, sp_exp, sp_tag);
    w = s < sp_prev;
    ne = w ? clampc(c, 10) : sp_rate;
    sp_rate = ne; sp_prev = s;
    sp_exp = model(s, ne, 1'b0, 10); sp_valid = 1; sp_tag = tag;
    s_sub = 10'(s); s_code = 4'(c);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint s;
    string tg;
    m_code = 4'd9;
    repeat (3) @(negedge clk);
    check(m_out, 1'b0, "R1 reset");
    check(s_out, 1'b0, "R1 reset small");
    rst_n = 1'b1;

    // R1: code 6 requested, but 1 Hz holds until the first rollover
    s = 0;
    for (int i = 0; i < 1500; i++) begin
      s = (s + 1_048_573) % BIN_WRAP;
      step_m(s, 1'b0, 6, "R1 rate after reset");
    end

    // R9: sub_sec constant at 150 ms, mode toggled every cycle
    for (int i = 0; i < 40; i++) step_m(150_000_000, i[0], 0, "R9 mode switch");

    // R3/R4/R5/R6 sweeps with R8 one-cycle latency
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 16; c++) begin
        longint wv = d ? NS_WRAP : BIN_WRAP;
        longint st = d ? 488_281 : 1_048_573;
        if (d == 0) tg = (c == 0) ? "R3,R8 binary" : "R4,R8 binary";
        else        tg = (c == 0) ? "R5,R8 decimal" : "R6,R8 decimal";
        s = 0;
        for (int i = 0; i < 2900; i++) begin
          step_m(s, d[0], c, tg);
          s = (s + st) % wv;
        end
      end
    end

    // R2: code changed mid-second takes effect only at the next rollover
    s = 0;
    for (int i = 0; i < 5000; i++) begin
      int c = (i < 1000) ? 1 : (i < 3000 ? 4 : 2);
      step_m(s, 1'b0, c, "R2 rollover load");
      s = (s + 1_048_573) % BIN_WRAP;
    end
    step_m(s, 1'b0, 2, "R2 rollover load");

    // R7 with R3/R4 exhaustive on 10-bit field
    for (int c = 0; c < 16; c++) begin
      tg = (c > 9) ? "R7 clamp" : ((c == 0) ? "R3 small" : "R4 small");
      for (int i = 0; i < 2100; i++) step_s(i % 1024, c, tg);
    end
    step_s(0, 0, "R7 clamp");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule